// File: doc/BRIEF.md
# Error-Line Fault Deferral Controller

This block sits inside a reporting node and decides what kind of report the node puts out when the error-reporting lines themselves go bad while a report is in flight. There are two such lines: the line shared by a bus and the line shared across a module. A fault on either line is not turned into a line-error report straight away. If it were, only part of the system might log it, and the nodes would then recover in different ways. Instead the block notes the fault in a per-line pending flag. If the node has nothing valid to forward, it asks for a placeholder "no error" report, which tells the system that something happened without changing how it recovers.

At the end of each reporting cycle, a set pending flag turns on a single override bit for the node. That bit lasts for exactly one reporting cycle. While it is on, a line fault is reported as a genuine line-error report, at the first chance in that cycle, so every node sees and logs it. A line with a permanent fault therefore gives a placeholder first and then a real line-error report in every later cycle. Serialising and driving the frames is done elsewhere. This block only produces the one-cycle report command: send strobe, type code and placeholder marker.

Top module: `err_line_defer`

## Requirements
- R1: During reset and in the first cycle after reset, `override_o`, `tx_send` and `tx_placeholder` are 0, and `tx_code` is 4'h0.
- R2: Each line has its own pending flag. A fault strobe on the bus line sets one flag and a fault strobe on the module line sets the other. Either flag makes `override_o` go to 1 at the next `cycle_end`.
- R3: A line fault seen with override off and `fwd_valid` low gives, one clock later, a one-cycle `tx_send` with `tx_placeholder`=1 and `tx_code`=4'h0 (the placeholder "no error" code).
- R4: A line fault seen with override off and `fwd_valid` high forwards `fwd_code` one clock later with `tx_placeholder`=0. No line-error code is produced for the fault.
- R5: At a `cycle_end` strobe, `override_o` takes the value "any pending flag set, or a line fault strobe in that same clock". Without `cycle_end`, `override_o` does not change.
- R6: A line fault seen with override on is reported one clock later as a line-error report: `MOD_CODE` for a module-line fault and `BUS_CODE` for a bus-line fault. When both lines fault in the same clock, `BUS_CODE` is sent. `tx_placeholder`=0.
- R7: Both pending flags clear at `cycle_end`. If a reporting cycle contains no line fault, override drops to 0 at that cycle's `cycle_end`.
- R8: When there is no line fault, `local_req` sends `local_code` one clock later with `tx_placeholder`=0. When there is no line fault and no `local_req`, `tx_send` is 0.
- R9: A module line with a permanent fault, faulting in three consecutive reporting cycles, gives the type sequence 4'h0 (placeholder), `MOD_CODE`, `MOD_CODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_line_fault | input | 1 | Strobe: fault found on the bus error line during a report |
| mod_line_fault | input | 1 | Strobe: fault found on the module error line during a report |
| cycle_end | input | 1 | Strobe: end of the current reporting cycle |
| local_req | input | 1 | Node wants to originate its own report |
| local_code | input | 4 | Type code of the local report |
| fwd_valid | input | 1 | Node holds a valid received report to pass on |
| fwd_code | input | 4 | Type code of the report to pass on |
| tx_send | output | 1 | One-cycle command to transmit a report |
| tx_code | output | 4 | Type code to transmit |
| tx_placeholder | output | 1 | The transmitted report is the "no error" placeholder |
| override_o | output | 1 | Current override state |

## Verification
The bench aims at the corner cases where a report is chosen wrongly. A fault arriving without override must give the placeholder and never a line code. A design that reported at once would leak a line-error report that only part of the system logs. The bench strobes a fault in the same clock as `cycle_end` and expects override to come on. A design that took only the registered pending flags would miss that fault, and the override would come one cycle late. It also checks that override does not survive an idle cycle, because a sticky override would let later faults be reported without the deferral. It checks that a simultaneous fault on both lines reports the bus-line code. The stuck module-line sequence then ties the whole chain together.

// File: rtl/errdef_pkg.sv
package errdef_pkg;

    localparam int NUM_LINES = 2;
    localparam int LINE_BUS  = 0;   // lower index wins when both lines fault
    localparam int LINE_MOD  = 1;

    typedef logic [3:0] err_code_t;

    localparam err_code_t NOERR_CODE = 4'h0;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_LOCAL,
        SRC_FWD,
        SRC_LINE
    } tx_src_e;

    typedef struct packed {
        logic      send;
        logic      placeholder;
        err_code_t code;
    } tx_word_t;

    localparam tx_word_t TX_IDLE = '{send: 1'b0, placeholder: 1'b0, code: NOERR_CODE};

    // Line-error code for the highest-priority faulting line.
    function automatic err_code_t line_code(line_vec_t f, err_code_t bus_c, err_code_t mod_c);
        err_code_t c;
        c = NOERR_CODE;
        if (f[LINE_MOD]) c = mod_c;
        if (f[LINE_BUS]) c = bus_c;
        return c;
    endfunction

endpackage

// File: rtl/line_pend_reg.sv
module line_pend_reg
    import errdef_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] fault,
    input  logic             cycle_end,
    output logic [LINES-1:0] pend
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= 1'b0;
            end else if (cycle_end) begin
                // sampled into override this edge, then cleared
                pend[i] <= 1'b0;
            end else if (fault[i]) begin
                pend[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/override_ctl.sv
module override_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cycle_end,
    input  logic pend_any,
    input  logic fault_any,
    output logic ovr
);

    logic ovr_d;

    always_comb begin
        ovr_d = ovr;
        if (cycle_end) begin
            ovr_d = pend_any | fault_any;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ovr <= 1'b0;
        else     ovr <= ovr_d;
    end

endmodule

// File: rtl/report_sel.sv
module report_sel
    import errdef_pkg::*;
#(
    parameter err_code_t MOD_CODE = 4'hA,
    parameter err_code_t BUS_CODE = 4'hB
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t fault,
    input  logic      ovr,
    input  logic      local_req,
    input  err_code_t local_code,
    input  logic      fwd_valid,
    input  err_code_t fwd_code,
    output tx_word_t  tx_q
);

    tx_src_e  src;
    tx_word_t tx_d;

    always_comb begin
        if (|fault) begin
            if (ovr)            src = SRC_LINE;
            else if (fwd_valid) src = SRC_FWD;
            else                src = SRC_IDLE;
        end else if (local_req) begin
            src = SRC_LOCAL;
        end else begin
            src = SRC_IDLE;
        end
    end

    always_comb begin
        tx_d = TX_IDLE;
        unique case (src)
            SRC_LINE:  tx_d = '{send: 1'b1, placeholder: 1'b0,
                                code: line_code(fault, BUS_CODE, MOD_CODE)};
            SRC_FWD:   tx_d = '{send: 1'b1, placeholder: 1'b0, code: fwd_code};
            SRC_LOCAL: tx_d = '{send: 1'b1, placeholder: 1'b0, code: local_code};
            SRC_IDLE: begin
                // fault with nothing to pass on: placeholder report
                if (|fault) tx_d = '{send: 1'b1, placeholder: 1'b1, code: NOERR_CODE};
            end
            default:   tx_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tx_q <= TX_IDLE;
        else     tx_q <= tx_d;
    end

endmodule

// File: rtl/err_line_defer.sv
module err_line_defer
    import errdef_pkg::*;
#(
    parameter logic [3:0] MOD_CODE = 4'hA,
    parameter logic [3:0] BUS_CODE = 4'hB
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_line_fault,
    input  logic       mod_line_fault,
    input  logic       cycle_end,
    input  logic       local_req,
    input  logic [3:0] local_code,
    input  logic       fwd_valid,
    input  logic [3:0] fwd_code,
    output logic       tx_send,
    output logic [3:0] tx_code,
    output logic       tx_placeholder,
    output logic       override_o
);

    line_vec_t fault_v;
    line_vec_t pend_v;
    logic      pend_any;
    logic      ovr;
    tx_word_t  tx_q;

    always_comb begin
        fault_v           = '0;
        fault_v[LINE_BUS] = bus_line_fault;
        fault_v[LINE_MOD] = mod_line_fault;
    end

    assign pend_any = |pend_v;

    line_pend_reg #(.LINES(NUM_LINES)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .fault     (fault_v),
        .cycle_end (cycle_end),
        .pend      (pend_v)
    );

    override_ctl u_ovr (
        .clk       (clk),
        .rst       (rst),
        .cycle_end (cycle_end),
        .pend_any  (pend_any),
        .fault_any (|fault_v),
        .ovr       (ovr)
    );

    report_sel #(.MOD_CODE(MOD_CODE), .BUS_CODE(BUS_CODE)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .fault      (fault_v),
        .ovr        (ovr),
        .local_req  (local_req),
        .local_code (local_code),
        .fwd_valid  (fwd_valid),
        .fwd_code   (fwd_code),
        .tx_q       (tx_q)
    );

    assign tx_send        = tx_q.send;
    assign tx_code        = tx_q.code;
    assign tx_placeholder = tx_q.placeholder;
    assign override_o     = ovr;

endmodule

// File: rtl/err_line_defer_chk.sv
module err_line_defer_chk #(
    parameter logic [3:0] MOD_CODE = 4'hA,
    parameter logic [3:0] BUS_CODE = 4'hB
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_line_fault,
    input logic       mod_line_fault,
    input logic       cycle_end,
    input logic       fwd_valid,
    input logic       pend_any,
    input logic       tx_send,
    input logic [3:0] tx_code,
    input logic       tx_placeholder,
    input logic       override_o
);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!override_o && !tx_send && !tx_placeholder));

    // R3
    placeholder_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_line_fault || mod_line_fault) && !override_o && !fwd_valid)
        |=> (tx_send && tx_placeholder && tx_code == 4'h0));

    // R5
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> $stable(override_o));

    // R2
    ovr_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && (pend_any || bus_line_fault || mod_line_fault)) |=> override_o);

    // R7
    ovr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !pend_any && !bus_line_fault && !mod_line_fault) |=> !override_o);

    // R6
    mod_report_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_line_fault && !bus_line_fault && override_o)
        |=> (tx_send && !tx_placeholder && tx_code == MOD_CODE));

    // R6
    bus_report_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_line_fault && override_o)
        |=> (tx_send && !tx_placeholder && tx_code == BUS_CODE));

endmodule

bind err_line_defer err_line_defer_chk #(.MOD_CODE(MOD_CODE), .BUS_CODE(BUS_CODE)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_line_fault (bus_line_fault),
    .mod_line_fault (mod_line_fault),
    .cycle_end      (cycle_end),
    .fwd_valid      (fwd_valid),
    .pend_any       (pend_any),
    .tx_send        (tx_send),
    .tx_code        (tx_code),
    .tx_placeholder (tx_placeholder),
    .override_o     (override_o)
);

// File: tb/err_line_defer_bench.sv
`timescale 1ns/1ps
module err_line_defer_bench;

    localparam logic [3:0] MODC = 4'hA;
    localparam logic [3:0] BUSC = 4'hB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_line_fault = 1'b0;
    logic       mod_line_fault = 1'b0;
    logic       cycle_end = 1'b0;
    logic       local_req = 1'b0;
    logic [3:0] local_code = 4'h0;
    logic       fwd_valid = 1'b0;
    logic [3:0] fwd_code = 4'h0;
    logic       tx_send;
    logic [3:0] tx_code;
    logic       tx_placeholder;
    logic       override_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    err_line_defer #(.MOD_CODE(MODC), .BUS_CODE(BUSC)) u_err_line_defer (
        .clk(clk), .rst(rst),
        .bus_line_fault(bus_line_fault), .mod_line_fault(mod_line_fault),
        .cycle_end(cycle_end), .local_req(local_req), .local_code(local_code),
        .fwd_valid(fwd_valid), .fwd_code(fwd_code),
        .tx_send(tx_send), .tx_code(tx_code), .tx_placeholder(tx_placeholder),
        .override_o(override_o)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one clock of stimulus from a negedge; outputs are sampled at the next negedge.
    task automatic step(logic bf, logic mf, logic ce, logic lr, logic [3:0] lc,
                        logic fv, logic [3:0] fc);
        bus_line_fault = bf; mod_line_fault = mf; cycle_end = ce;
        local_req = lr; local_code = lc; fwd_valid = fv; fwd_code = fc;
        @(negedge clk);
        bus_line_fault = 0; mod_line_fault = 0; cycle_end = 0;
        local_req = 0; local_code = 0; fwd_valid = 0; fwd_code = 0;
    endtask

    task automatic tx_expect(string req, logic s, logic p, logic [3:0] c);
        check(req, "tx_send", tx_send, s);
        check(req, "tx_placeholder", tx_placeholder, p);
        if (s) check(req, "tx_code", tx_code, c);
    endtask

    task automatic end_cycle(); step(0,0,1,0,0,0,0); endtask

    task automatic clear_override();
        end_cycle(); end_cycle();
        check("R7", "override cleared", override_o, 0);
    endtask

    task automatic t_reset();
        check("R1", "override", override_o, 0);
        tx_expect("R1", 0, 0, 0);
        check("R1", "tx_code", tx_code, 0);
    endtask

    task automatic t_placeholder_and_arm_mod();
        step(0,1,0,0,0,0,0);
        tx_expect("R3", 1, 1, 4'h0);
        check("R5", "override holds without cycle_end", override_o, 0);
        end_cycle();
        check("R2", "module pending arms override", override_o, 1);
        end_cycle();
        check("R7", "idle cycle drops override", override_o, 0);
    endtask

    task automatic t_forward_and_arm_bus();
        step(1,0,0,0,0,1,4'h5);
        tx_expect("R4", 1, 0, 4'h5);
        end_cycle();
        check("R2", "bus pending arms override", override_o, 1);
        clear_override();
    endtask

    task automatic t_fault_at_end();
        step(0,1,1,0,0,0,0);
        tx_expect("R3", 1, 1, 4'h0);
        check("R5", "fault on cycle_end edge arms override", override_o, 1);
        clear_override();
    endtask

    task automatic t_override_reports();
        step(1,0,0,0,0,0,0);
        end_cycle();
        step(0,1,0,0,0,1,4'h3);
        tx_expect("R6", 1, 0, MODC);
        step(1,1,0,0,0,0,0);
        tx_expect("R6", 1, 0, BUSC);
        step(1,0,0,0,0,0,0);
        tx_expect("R6", 1, 0, BUSC);
        end_cycle();
        check("R7", "new fault keeps override", override_o, 1);
        clear_override();
    endtask

    task automatic t_local();
        step(0,0,0,1,4'h7,0,0);
        tx_expect("R8", 1, 0, 4'h7);
        step(0,0,0,0,0,1,4'h9);
        tx_expect("R8", 0, 0, 0);
    endtask

    task automatic t_stuck_mod();
        step(0,1,0,0,0,0,0);
        tx_expect("R9", 1, 1, 4'h0);
        end_cycle();
        step(0,1,0,1,MODC,0,0);
        tx_expect("R9", 1, 0, MODC);
        end_cycle();
        step(0,1,0,1,MODC,0,0);
        tx_expect("R9", 1, 0, MODC);
        end_cycle();
        clear_override();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        t_placeholder_and_arm_mod();
        t_forward_and_arm_bus();
        t_fault_at_end();
        t_override_reports();
        t_local();
        t_stuck_mod();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule